// File: doc/BRIEF.md
# Transmit Alignment Pad Stripper

This block sits on the transmit path in front of a 10G Ethernet MAC. Frames arrive on a 64-bit AXI4-Stream in which every frame begins with a six-byte internal pad. The block drops that pad and realigns the rest of the frame, so the destination MAC address starts at byte 0 of the first output word. The stream leaving the block carries the data, a start-of-frame flag and the number of valid bytes in the final word.

The realignment keeps the top two bytes of each accepted word. It joins them with the bottom six bytes of the next word. Because six bytes are removed, a frame can leave one word shorter than it arrived. A frame can also need one extra beat to drain the last two bytes, and the input is stalled for that beat. Backpressure works in both directions. Output data, valid and last are formed combinationally from the held bytes and the current input word. Each input frame is expected to carry at least two words, which any real Ethernet frame does once the pad is added.

Top module: `tx_pad_strip`

## Requirements
- R1: After reset the output is idle (`m_tvalid` low), the input is ready (`s_tready` high), and the next output beat is marked as start of frame.
- R2: Byte k of a word lies at bits 8k+7:8k, and byte 0 is first on the wire. The first six bytes of each input frame never appear at the output, so output byte 0 of a frame's first beat is input byte 6 of that frame.
- R3: Every output beat that is not a drain beat holds, in order, bytes 6 and 7 of one input word followed by bytes 0 to 5 of the next input word of the same frame.
- R4: The byte count sits in `s_tuser[2:0]` and `m_tuser[2:0]`, and 0 means 8. It is read only on the input's last word. The output count on the last beat equals the input count plus 2, modulo 8. The count is 0 on all other output beats.
- R5: If the last input word holds 1 to 6 valid bytes, the frame ends on the beat that merges it, and that beat carries `m_tlast`. The output frame is one word shorter than the input frame.
- R6: If the last input word holds 7 or 8 valid bytes, one extra final beat carries its bytes 6 and 7 with `m_tlast`. No input word is accepted while that beat is pending.
- R7: `m_tuser[3]` is high on the first beat of every output frame and low on every other beat.
- R8: `s_tuser[3]` (an error flag) has no effect on any output.
- R9: Under any pattern of `s_tvalid` and `m_tready` stalls, no beat is lost or duplicated. An output beat that is offered but not accepted stays unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 64 | Input frame data, pad in first six bytes |
| s_tuser | input | 4 | [2:0] last-word byte count, [3] error flag (ignored) |
| s_tlast | input | 1 | Last word of input frame |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Input word accepted |
| m_tdata | output | 64 | Realigned frame data |
| m_tuser | output | 4 | [2:0] last-beat byte count, [3] start of frame |
| m_tlast | output | 1 | Last beat of output frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |

## Verification
The hardest case to reach is the drain beat of a frame whose last word holds 7 or 8 bytes, arriving while the sink is stalling. The last input word must be accepted, and then the drain beat must be held with the input blocked. Only after that can the next frame's first word enter idle state. The bench cycles every last-word count against frame lengths of two to seven words. It runs these through segments with steady flow, balanced random stalls, a mostly stalled sink, and a sparse source. A behavioural byte-queue model predicts each output beat, and the bench compares it on every cycle in which a transfer occurs.

// File: rtl/pad_strip_pkg.sv
package pad_strip_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MERGE = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;

endpackage

// File: rtl/pad_strip_count.sv
module pad_strip_count #(
    parameter int BYTES = 8,
    parameter int PAD   = 6,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flush_o
);
    localparam int SHIFT = BYTES - PAD;

    logic [CNT_W:0] valid_bytes;

    always_comb begin
        valid_bytes = (cnt_i == '0) ? (CNT_W+1)'(BYTES) : {1'b0, cnt_i};
        flush_o     = valid_bytes > (CNT_W+1)'(PAD);
        cnt_o       = cnt_i + CNT_W'(SHIFT);
    end

endmodule

// File: rtl/pad_strip_merge.sv
module pad_strip_merge #(
    parameter int DATA_W = 64,
    parameter int PAD    = 6
) (
    input  logic [(DATA_W/8-PAD)*8-1:0] held_i,
    input  logic [PAD*8-1:0]            cur_i,
    input  logic                        flush_i,
    output logic [DATA_W-1:0]           data_o
);
    localparam int BYTES = DATA_W / 8;
    localparam int KEEP  = BYTES - PAD;

    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        if (j < KEEP) begin : g_held
            assign data_o[8*j +: 8] = held_i[8*j +: 8];
        end else begin : g_cur
            assign data_o[8*j +: 8] = flush_i ? 8'h00 : cur_i[8*(j-KEEP) +: 8];
        end
    end

endmodule

// File: rtl/pad_strip_ctrl.sv
module pad_strip_ctrl
    import pad_strip_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int HELD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic [HELD_W-1:0] s_hi,
    input  logic              in_flush,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic              m_ready,
    output logic              s_ready,
    output logic              m_valid,
    output logic              m_last,
    output logic [CNT_W-1:0]  m_cnt,
    output logic              m_sof,
    output logic [HELD_W-1:0] held_o,
    output logic              flushing_o
);
    typedef struct packed {
        phase_e              phase;
        logic                sof;
        logic [CNT_W-1:0]    cnt;
        logic [HELD_W-1:0]   held;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_last  = 1'b0;
        m_cnt   = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    st_d.held = s_hi;
                    if (!s_last) begin
                        st_d.phase = PH_MERGE;
                    end else if (in_flush) begin
                        st_d.phase = PH_FLUSH;
                        st_d.cnt   = in_cnt;
                    end
                end
            end
            PH_MERGE: begin
                m_valid = s_valid;
                s_ready = m_ready;
                if (s_last && !in_flush) begin
                    m_last = 1'b1;
                    m_cnt  = in_cnt;
                end
                if (s_valid && m_ready) begin
                    st_d.sof  = m_last;
                    st_d.held = s_hi;
                    if (s_last) begin
                        st_d.phase = in_flush ? PH_FLUSH : PH_IDLE;
                        st_d.cnt   = in_cnt;
                    end
                end
            end
            PH_FLUSH: begin
                m_valid = 1'b1;
                m_last  = 1'b1;
                m_cnt   = st_q.cnt;
                if (m_ready) begin
                    st_d.phase = PH_IDLE;
                    st_d.sof   = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, sof: 1'b1, cnt: '0, held: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign m_sof      = st_q.sof & m_valid;
    assign held_o     = st_q.held;
    assign flushing_o = (st_q.phase == PH_FLUSH);

endmodule

// File: rtl/tx_pad_strip.sv
module tx_pad_strip #(
    parameter int DATA_W    = 64,
    parameter int PAD_BYTES = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [DATA_W-1:0]               s_tdata,
    input  logic [$clog2(DATA_W/8):0]       s_tuser,
    input  logic                            s_tlast,
    input  logic                            s_tvalid,
    output logic                            s_tready,
    output logic [DATA_W-1:0]               m_tdata,
    output logic [$clog2(DATA_W/8):0]       m_tuser,
    output logic                            m_tlast,
    output logic                            m_tvalid,
    input  logic                            m_tready
);
    localparam int BYTES  = DATA_W / 8;
    localparam int CNT_W  = $clog2(BYTES);
    localparam int KEEP   = BYTES - PAD_BYTES;
    localparam int HELD_W = KEEP * 8;
    localparam int LOW_W  = PAD_BYTES * 8;

    logic [CNT_W-1:0]  cnt_shift;
    logic              need_flush;
    logic [CNT_W-1:0]  out_cnt;
    logic              out_sof;
    logic [HELD_W-1:0] held;
    logic              flushing;

    pad_strip_count #(
        .BYTES (BYTES),
        .PAD   (PAD_BYTES),
        .CNT_W (CNT_W)
    ) u_count (
        .cnt_i   (s_tuser[CNT_W-1:0]),
        .cnt_o   (cnt_shift),
        .flush_o (need_flush)
    );

    pad_strip_ctrl #(
        .CNT_W  (CNT_W),
        .HELD_W (HELD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .s_valid    (s_tvalid),
        .s_last     (s_tlast),
        .s_hi       (s_tdata[DATA_W-1 -: HELD_W]),
        .in_flush   (need_flush),
        .in_cnt     (cnt_shift),
        .m_ready    (m_tready),
        .s_ready    (s_tready),
        .m_valid    (m_tvalid),
        .m_last     (m_tlast),
        .m_cnt      (out_cnt),
        .m_sof      (out_sof),
        .held_o     (held),
        .flushing_o (flushing)
    );

    pad_strip_merge #(
        .DATA_W (DATA_W),
        .PAD    (PAD_BYTES)
    ) u_merge (
        .held_i  (held),
        .cur_i   (s_tdata[LOW_W-1:0]),
        .flush_i (flushing),
        .data_o  (m_tdata)
    );

    assign m_tuser = {out_sof, out_cnt};

endmodule

// File: rtl/tx_pad_strip_chk.sv
module tx_pad_strip_chk #(
    parameter int DATA_W    = 64,
    parameter int PAD_BYTES = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic [DATA_W-1:0]         s_tdata,
    input logic [$clog2(DATA_W/8):0] s_tuser,
    input logic                      s_tlast,
    input logic                      s_tvalid,
    input logic                      s_tready,
    input logic [DATA_W-1:0]         m_tdata,
    input logic [$clog2(DATA_W/8):0] m_tuser,
    input logic                      m_tlast,
    input logic                      m_tvalid,
    input logic                      m_tready
);
    localparam int BYTES = DATA_W / 8;
    localparam int CNT_W = $clog2(BYTES);

    logic [CNT_W:0] last_bytes;
    logic           in_fire;
    logic           out_fire;

    assign last_bytes = (s_tuser[CNT_W-1:0] == '0) ? (CNT_W+1)'(BYTES)
                                                   : {1'b0, s_tuser[CNT_W-1:0]};
    assign in_fire    = s_tvalid && s_tready;
    assign out_fire   = m_tvalid && m_tready;

    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser))); // R9

    AST_NO_SILENT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !m_tready) |-> !m_tvalid); // R9

    AST_SOF_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (out_fire && m_tlast) |=> (!m_tvalid || m_tuser[CNT_W])); // R7

    AST_SOF_ONLY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (out_fire && !m_tlast) |=> !m_tuser[CNT_W]); // R7

    AST_SHORT_END: assert property (@(posedge clk) disable iff (rst)
        (in_fire && s_tlast && m_tvalid && last_bytes <= (CNT_W+1)'(PAD_BYTES)) |-> m_tlast); // R5

    AST_DRAIN_BEAT: assert property (@(posedge clk) disable iff (rst)
        (in_fire && s_tlast && m_tvalid && last_bytes > (CNT_W+1)'(PAD_BYTES))
        |=> (m_tvalid && m_tlast && !s_tready)); // R6

    AST_MID_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |-> (m_tuser[CNT_W-1:0] == '0)); // R4

endmodule

bind tx_pad_strip tx_pad_strip_chk #(
    .DATA_W    (DATA_W),
    .PAD_BYTES (PAD_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_tdata  (s_tdata),
    .s_tuser  (s_tuser),
    .s_tlast  (s_tlast),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready)
);

// File: tb/tb_tx_pad_strip.sv
module tb_tx_pad_strip;
    localparam int PAD = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] s_tdata = '0;
    logic [3:0]  s_tuser = '0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic [3:0]  m_tuser;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b0;

    always #10 clk = ~clk;

    tx_pad_strip dut (
        .clk      (clk),
        .rst      (rst),
        .s_tdata  (s_tdata),
        .s_tuser  (s_tuser),
        .s_tlast  (s_tlast),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .m_tdata  (m_tdata),
        .m_tuser  (m_tuser),
        .m_tlast  (m_tlast),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready)
    );

    int total = 0;
    int bad   = 0;

    logic [63:0] in_d[$];
    logic [3:0]  in_u[$];
    bit          in_l[$];
    logic [63:0] ex_d[$];
    int          ex_c[$];
    bit          ex_l[$];
    bit          ex_s[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic add_frame(input int nw, input int c);
        byte unsigned b[$];
        int v, len, m, nwo;
        v   = (c == 0) ? 8 : c;
        len = 8 * (nw - 1) + v;
        for (int i = 0; i < nw * 8; i++) b.push_back(8'($urandom));
        for (int i = 0; i < nw; i++) begin
            logic [63:0] w;
            for (int j = 0; j < 8; j++) w[8*j +: 8] = b[8*i + j];
            in_d.push_back(w);
            in_u.push_back({1'($urandom), (i == nw - 1) ? 3'(c) : 3'd0});
            in_l.push_back(i == nw - 1);
        end
        m   = len - PAD;
        nwo = (m + 7) / 8;
        for (int k = 0; k < nwo; k++) begin
            logic [63:0] w;
            w = '0;
            for (int j = 0; j < 8; j++) if (8*k + j < m) w[8*j +: 8] = b[PAD + 8*k + j];
            ex_d.push_back(w);
            ex_c.push_back((k == nwo - 1) ? (m % 8) : 0);
            ex_l.push_back(k == nwo - 1);
            ex_s.push_back(k == 0);
        end
    endtask

    task automatic run_seg(input int vp, input int rp, input int nframes, input int off);
        bit holding;
        int cyc;
        holding = 1'b0;
        cyc     = 0;
        for (int f = 0; f < nframes; f++) add_frame(2 + (f + off) % 6, f % 8);
        while ((in_d.size() > 0 || ex_d.size() > 0) && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (!holding) begin
                if (in_d.size() > 0 && $urandom_range(99) < vp) begin
                    s_tvalid = 1'b1;
                    s_tdata  = in_d[0];
                    s_tuser  = in_u[0];
                    s_tlast  = in_l[0];
                    holding  = 1'b1;
                end else begin
                    s_tvalid = 1'b0;
                    s_tdata  = {$urandom, $urandom};
                    s_tuser  = 4'($urandom);
                    s_tlast  = 1'($urandom);
                end
            end
            m_tready = ($urandom_range(99) < rp);
            #5;
            if (m_tvalid && m_tready) begin
                if (ex_d.size() == 0) begin
                    chk(1'b0, "R9 beat with nothing expected", m_tdata, '0);
                end else begin
                    logic [63:0] mask;
                    int vb;
                    vb   = ex_l[0] ? ((ex_c[0] == 0) ? 8 : ex_c[0]) : 8;
                    mask = (vb == 8) ? '1 : ((64'd1 << (8 * vb)) - 64'd1);
                    chk((m_tdata & mask) == ex_d[0], "R2/R3/R8 data", m_tdata & mask, ex_d[0]);
                    chk(m_tlast == ex_l[0], "R5/R6 tlast", 64'(m_tlast), 64'(ex_l[0]));
                    chk(int'(m_tuser[2:0]) == ex_c[0], "R4 byte count", 64'(m_tuser[2:0]), 64'(ex_c[0]));
                    chk(m_tuser[3] == ex_s[0], "R7/R8 start of frame", 64'(m_tuser[3]), 64'(ex_s[0]));
                    void'(ex_d.pop_front());
                    void'(ex_c.pop_front());
                    void'(ex_l.pop_front());
                    void'(ex_s.pop_front());
                end
            end
            if (s_tvalid && s_tready) begin
                void'(in_d.pop_front());
                void'(in_u.pop_front());
                void'(in_l.pop_front());
                holding = 1'b0;
            end
        end
        if (cyc >= 40000) chk(1'b0, "R9 watchdog expired", 64'(cyc), 64'(0));
        chk(in_d.size() == 0 && ex_d.size() == 0, "R9 all beats delivered",
            64'(in_d.size() + ex_d.size()), 64'(0));
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk(!m_tvalid, "R1 output idle after reset", 64'(m_tvalid), 64'(0));
        chk(s_tready, "R1 input ready after reset", 64'(s_tready), 64'(1));
        run_seg(100, 100, 48, 0);
        run_seg(60, 60, 48, 1);
        run_seg(90, 20, 48, 2);
        run_seg(30, 95, 48, 3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule